// File: doc/BRIEF.md
# Floating-Point Exception Trap Controller

This block sits beside a floating-point execution pipe. When an operation completes, it decides whether that operation must trap, which cause to report, which exception flags to record and whether the result must be replaced by a NaN. The pipe supplies the following with the completion strobe:

- the kind of operation;
- the software-completion qualifier;
- a class code for each of the two operands;
- the two operand bit patterns;
- the raw exception conditions found by the arithmetic datapath.

A control word supplies a denormal-as-zero enable and five per-exception trap disables. A control-register write strobe clears the recorded flags.

Only arithmetic operations are screened. Copy-sign, conditional-move and control-register moves, and trap barriers, pass through untouched: trap barriers are no-ops because exceptions are already precise. Denormal inputs trap unless denormal-as-zero is enabled and the operation carries the software-completion qualifier. No disable bit can mask that trap. Signaling NaNs raise invalid. NaN inputs are propagated with their quiet bit set. An invalid result with no NaN input is replaced by one canonical quiet NaN.

Top module: `fpx_trap_ctrl`

## Requirements
- R1: While reset is asserted and after it is released with no operation, trap_req, nan_ovr and sticky_flags are 0, trap_cause is 0 and nan_val is 0.
- R2: trap_req, trap_cause, nan_ovr and nan_val are registered. They reflect the operation strobed by op_done in the previous cycle. In a cycle after one with op_done low, trap_req is 0 and trap_cause is 0.
- R3: For an arithmetic operation (op_kind 0) with a denormal operand (class code 1) and ctl_dnz clear, trap_req is 1 with trap_cause 1, whatever ctl_dis holds.
- R4: For an arithmetic operation with a denormal operand, no denormal trap is raised when ctl_dnz and op_swc are both 1. If either of them is 0, the denormal trap is raised.
- R5: For op_kind 1 (move/copy/control access), 2 (trap barrier) or 3, there is no trap, no NaN override and no change to sticky_flags. This holds for any operand classes and any raw_exc.
- R6: raw_exc and ctl_dis share one bit order: bit 0 invalid, bit 1 divide-by-zero, bit 2 overflow, bit 3 underflow, bit 4 inexact. A raised condition traps only when its ctl_dis bit is 0.
- R7: When several trap reasons coincide, the cause is the first in this order: denormal (1), invalid (2), divide-by-zero (3), overflow (4), underflow (5), inexact (6). Code 0 means no trap.
- R8: A signaling NaN operand (class code 5) to an arithmetic operation raises the invalid condition.
- R9: If either operand is a NaN (class 4 quiet or 5 signaling), nan_ovr is 1. nan_val is that operand's bits with the quiet bit (fraction MSB, bit FRAC_W-1) set. Operand A wins when both are NaN.
- R10: If invalid is raised and neither operand is a NaN, nan_ovr is 1 and nan_val is the canonical quiet NaN: sign 0, exponent all ones, fraction MSB 1, other fraction bits 0.
- R11: An infinity operand (class code 3) by itself causes no trap and no flag.
- R12: Each raised condition sets its sticky_flags bit (same bit order as R6), even when its disable bit suppresses the trap. sticky_flags are cleared by ctl_wr. A write in the same cycle as an operation keeps only that operation's new flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_done | input | 1 | Operation completion strobe |
| op_kind | input | 2 | 0 arithmetic, 1 move/copy/control access, 2 trap barrier, 3 treated as non-arithmetic |
| op_swc | input | 1 | Software-completion qualifier |
| cls_a | input | 3 | Operand A class: 0 zero, 1 denormal, 2 normal, 3 infinity, 4 quiet NaN, 5 signaling NaN |
| cls_b | input | 3 | Operand B class, same coding |
| opnd_a | input | 1+EXP_W+FRAC_W | Operand A bits |
| opnd_b | input | 1+EXP_W+FRAC_W | Operand B bits |
| raw_exc | input | 5 | Datapath exception conditions, bit order as R6 |
| ctl_dnz | input | 1 | Denormal-as-zero enable |
| ctl_dis | input | 5 | Per-exception trap disables, bit order as R6 |
| ctl_wr | input | 1 | Control-register write strobe, clears sticky flags |
| trap_req | output | 1 | Trap request, one cycle after op_done |
| trap_cause | output | 3 | Cause code as R7 |
| sticky_flags | output | 5 | Recorded exception flags |
| nan_ovr | output | 1 | Result must be replaced by nan_val |
| nan_val | output | 1+EXP_W+FRAC_W | Replacement NaN |

## Verification
The first sweep covers every pair of operand classes for every operation kind, qualifier and denormal-as-zero setting. It uses rotating raw-exception and disable patterns. This separates denormal handling from NaN propagation, signaling-NaN invalid and the non-arithmetic bypass. The second sweep covers all 1024 combinations of raw conditions and disable masks on normal operands. It separates the priority encoding from the masking, and the sticky recording from the trap decision. Directed sequences then clear the flags on a write, alone and together with an operation, and check idle cycles between operations.

// File: rtl/fpx_pkg.sv
package fpx_pkg;

  localparam int NUM_EXC = 5;
  localparam int EXC_INV = 0;
  localparam int EXC_DZ  = 1;
  localparam int EXC_OVF = 2;
  localparam int EXC_UNF = 3;
  localparam int EXC_INX = 4;

  typedef enum logic [2:0] {
    CLS_ZERO   = 3'd0,
    CLS_DENORM = 3'd1,
    CLS_NORMAL = 3'd2,
    CLS_INF    = 3'd3,
    CLS_QNAN   = 3'd4,
    CLS_SNAN   = 3'd5
  } opclass_e;

  typedef enum logic [1:0] {
    KIND_ARITH   = 2'd0,
    KIND_MOVE    = 2'd1,
    KIND_BARRIER = 2'd2,
    KIND_RSVD    = 2'd3
  } opkind_e;

  localparam logic [2:0] CAUSE_NONE   = 3'd0;
  localparam logic [2:0] CAUSE_DENORM = 3'd1;

  // Cause code of an exception index: codes follow the denormal code.
  function automatic logic [2:0] cause_of_exc(input int idx);
    return 3'(idx + 2);
  endfunction

  function automatic logic is_nan_class(input logic [2:0] c);
    return (c == CLS_QNAN) || (c == CLS_SNAN);
  endfunction

endpackage

// File: rtl/fpx_operand_screen.sv
module fpx_operand_screen
  import fpx_pkg::*;
#(
  parameter int EXP_W = 11,
  parameter int FRAC_W = 52,
  parameter int NOPS = 2,
  localparam int DW = 1 + EXP_W + FRAC_W
) (
  input  logic [NOPS-1:0][2:0]    cls,
  input  logic [NOPS-1:0][DW-1:0] data,
  output logic                    any_denorm,
  output logic                    any_snan,
  output logic                    any_nan,
  output logic [DW-1:0]           nan_src
);

  localparam logic [DW-1:0] QUIET_MASK = DW'(1) << (FRAC_W - 1);

  function automatic logic [DW-1:0] quieten(input logic [DW-1:0] v);
    return v | QUIET_MASK;
  endfunction

  logic [NOPS-1:0] is_den;
  logic [NOPS-1:0] is_snan;
  logic [NOPS-1:0] is_nan;

  for (genvar i = 0; i < NOPS; i++) begin : g_op
    assign is_den[i]  = (cls[i] == CLS_DENORM);
    assign is_snan[i] = (cls[i] == CLS_SNAN);
    assign is_nan[i]  = is_nan_class(cls[i]);
  end

  assign any_denorm = |is_den;
  assign any_snan   = |is_snan;
  assign any_nan    = |is_nan;

  // Lowest-numbered NaN operand supplies the propagated payload.
  always_comb begin
    nan_src = '0;
    for (int i = NOPS - 1; i >= 0; i--) begin
      if (is_nan[i]) nan_src = quieten(data[i]);
    end
  end

endmodule

// File: rtl/fpx_cause_arbiter.sv
module fpx_cause_arbiter
  import fpx_pkg::*;
#(
  parameter int N = NUM_EXC
) (
  input  logic         den_trap,
  input  logic [N-1:0] exc_enabled,
  output logic [N-1:0] grant,
  output logic [2:0]   cause
);

  logic [N:0] seen;
  assign seen[0] = den_trap;

  for (genvar i = 0; i < N; i++) begin : g_pri
    assign grant[i]  = exc_enabled[i] & ~seen[i];
    assign seen[i+1] = seen[i] | exc_enabled[i];
  end

  always_comb begin
    cause = den_trap ? CAUSE_DENORM : CAUSE_NONE;
    for (int i = 0; i < N; i++) begin
      if (grant[i]) cause = cause_of_exc(i);
    end
  end

endmodule

// File: rtl/fpx_sticky_bank.sv
module fpx_sticky_bank #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic [N-1:0] set,
  output logic [N-1:0] q
);

  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q[i] <= 1'b0;
      else        q[i] <= (q[i] & ~clr) | set[i];
    end
  end

endmodule

// File: rtl/fpx_trap_ctrl.sv
module fpx_trap_ctrl
  import fpx_pkg::*;
#(
  parameter int EXP_W = 11,
  parameter int FRAC_W = 52,
  localparam int DW = 1 + EXP_W + FRAC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_done,
  input  logic [1:0]        op_kind,
  input  logic              op_swc,
  input  logic [2:0]        cls_a,
  input  logic [2:0]        cls_b,
  input  logic [DW-1:0]     opnd_a,
  input  logic [DW-1:0]     opnd_b,
  input  logic [NUM_EXC-1:0] raw_exc,
  input  logic              ctl_dnz,
  input  logic [NUM_EXC-1:0] ctl_dis,
  input  logic              ctl_wr,
  output logic              trap_req,
  output logic [2:0]        trap_cause,
  output logic [NUM_EXC-1:0] sticky_flags,
  output logic              nan_ovr,
  output logic [DW-1:0]     nan_val
);

  localparam logic [DW-1:0] CANON_QNAN =
    {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

  // Named internal events
  logic               is_arith;
  logic               op_active;
  logic               any_denorm, any_snan, any_nan;
  logic [DW-1:0]      nan_src;
  logic               den_trap;
  logic [NUM_EXC-1:0] exc_raised;
  logic [NUM_EXC-1:0] exc_enabled;
  logic [NUM_EXC-1:0] grant;
  logic [2:0]         cause_d;
  logic               nan_ovr_d;
  logic [DW-1:0]      nan_val_d;

  fpx_operand_screen #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .NOPS(2)) u_screen (
    .cls        ({cls_b, cls_a}),
    .data       ({opnd_b, opnd_a}),
    .any_denorm (any_denorm),
    .any_snan   (any_snan),
    .any_nan    (any_nan),
    .nan_src    (nan_src)
  );

  assign is_arith  = (op_kind == KIND_ARITH);
  assign op_active = op_done & is_arith;
  assign den_trap  = op_active & any_denorm & ~(ctl_dnz & op_swc);

  always_comb begin
    exc_raised = '0;
    if (op_active) begin
      exc_raised = raw_exc;
      exc_raised[EXC_INV] = raw_exc[EXC_INV] | any_snan;
    end
  end

  assign exc_enabled = exc_raised & ~ctl_dis;

  fpx_cause_arbiter #(.N(NUM_EXC)) u_arb (
    .den_trap    (den_trap),
    .exc_enabled (exc_enabled),
    .grant       (grant),
    .cause       (cause_d)
  );

  assign nan_ovr_d = op_active & (any_nan | exc_raised[EXC_INV]);
  assign nan_val_d = !nan_ovr_d ? '0 : (any_nan ? nan_src : CANON_QNAN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trap_req   <= 1'b0;
      trap_cause <= CAUSE_NONE;
      nan_ovr    <= 1'b0;
      nan_val    <= '0;
    end else begin
      trap_req   <= (cause_d != CAUSE_NONE);
      trap_cause <= cause_d;
      nan_ovr    <= nan_ovr_d;
      nan_val    <= nan_val_d;
    end
  end

  fpx_sticky_bank #(.N(NUM_EXC)) u_sticky (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (ctl_wr),
    .set   (exc_raised),
    .q     (sticky_flags)
  );

  // Assertions next to the logic they guard
  AST_IDLE_NO_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
    !op_done |=> (!trap_req && trap_cause == CAUSE_NONE)); // R2

  AST_DENORM_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (op_done && op_kind == KIND_ARITH && any_denorm && !ctl_dnz)
      |=> (trap_req && trap_cause == CAUSE_DENORM)); // R3

  AST_NONARITH_NO_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (op_done && op_kind != KIND_ARITH) |=> (!trap_req && !nan_ovr)); // R5

  AST_SINGLE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant)); // R7

  AST_NAN_IS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    nan_ovr |-> (nan_val[FRAC_W-1] && (&nan_val[DW-2 -: EXP_W]))); // R9

  AST_STICKY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_wr |=> ((sticky_flags & $past(sticky_flags)) == $past(sticky_flags))); // R12

  AST_STICKY_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && !op_done) |=> (sticky_flags == '0)); // R12

endmodule

// File: tb/tb_fpx_trap_ctrl.sv
module tb_fpx_trap_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int DW = 64;
  localparam logic [63:0] QBIT  = 64'h0008_0000_0000_0000;
  localparam logic [63:0] CANON = 64'h7FF8_0000_0000_0000;
  localparam logic [63:0] MARK_A = 64'h0000_0000_0000_1234;
  localparam logic [63:0] MARK_B = 64'h0000_0000_0000_0567;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic op_done = 1'b0;
  logic [1:0] op_kind = '0;
  logic op_swc = 1'b0;
  logic [2:0] cls_a = '0, cls_b = '0;
  logic [DW-1:0] opnd_a = '0, opnd_b = '0;
  logic [4:0] raw_exc = '0;
  logic ctl_dnz = 1'b0;
  logic [4:0] ctl_dis = '0;
  logic ctl_wr = 1'b0;
  logic trap_req;
  logic [2:0] trap_cause;
  logic [4:0] sticky_flags;
  logic nan_ovr;
  logic [DW-1:0] nan_val;

  int n_checks = 0;
  int n_errors = 0;
  logic [4:0] exp_sticky = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fpx_trap_ctrl dut (
    .clk(clk), .rst_n(rst_n), .op_done(op_done), .op_kind(op_kind),
    .op_swc(op_swc), .cls_a(cls_a), .cls_b(cls_b), .opnd_a(opnd_a),
    .opnd_b(opnd_b), .raw_exc(raw_exc), .ctl_dnz(ctl_dnz), .ctl_dis(ctl_dis),
    .ctl_wr(ctl_wr), .trap_req(trap_req), .trap_cause(trap_cause),
    .sticky_flags(sticky_flags), .nan_ovr(nan_ovr), .nan_val(nan_val)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] pattern(input int c, input logic [63:0] mark);
    case (c)
      0: return 64'h0;
      1: return mark;                          // exponent zero, fraction nonzero
      2: return 64'h3FF0_0000_0000_0000 | mark;
      3: return 64'h7FF0_0000_0000_0000;
      4: return 64'h7FF8_0000_0000_0000 | mark;
      default: return 64'h7FF0_0000_0000_0000 | mark;
    endcase
  endfunction

  // Reference: list of trap reasons in rank order, first one wins.
  function automatic logic [2:0] ref_cause(input int k, input int a, input int b,
      input bit swc, input bit dnz, input logic [4:0] raw, input logic [4:0] dis);
    logic [4:0] cond;
    if (k != 0) return 3'd0;
    if ((a == 1 || b == 1) && !(dnz && swc)) return 3'd1;
    cond = raw;
    if (a == 5 || b == 5) cond[0] = 1'b1;
    for (int r = 0; r < 5; r++) if (cond[r] && !dis[r]) return 3'(r + 2);
    return 3'd0;
  endfunction

  task automatic run_op(input int k, input int a, input int b, input bit swc,
      input bit dnz, input logic [4:0] raw, input logic [4:0] dis, input bit wr);
    logic [2:0] ec;
    logic [4:0] cond;
    logic eo;
    logic [63:0] ev;
    string tag;
    @(negedge clk);
    op_done = 1'b1; op_kind = 2'(k); cls_a = 3'(a); cls_b = 3'(b);
    opnd_a = pattern(a, MARK_A); opnd_b = pattern(b, MARK_B);
    op_swc = swc; ctl_dnz = dnz; raw_exc = raw; ctl_dis = dis; ctl_wr = wr;
    ec = ref_cause(k, a, b, swc, dnz, raw, dis);
    cond = raw;
    if (a == 5 || b == 5) cond[0] = 1'b1;
    if (k != 0) cond = '0;
    if (wr) exp_sticky = '0;
    exp_sticky = exp_sticky | cond;
    eo = 1'b0; ev = '0;
    if (k == 0 && (a >= 4)) begin eo = 1'b1; ev = pattern(a, MARK_A) | QBIT; end
    else if (k == 0 && (b >= 4)) begin eo = 1'b1; ev = pattern(b, MARK_B) | QBIT; end
    else if (k == 0 && cond[0]) begin eo = 1'b1; ev = CANON; end
    if (k != 0) tag = "R5";
    else if (a == 1 || b == 1) tag = (dnz && swc) ? "R4" : "R3";
    else if (a == 5 || b == 5) tag = "R8";
    else if (a == 3 || b == 3) tag = "R11";
    else tag = "R6 R7";
    @(negedge clk);
    op_done = 1'b0; ctl_wr = 1'b0;
    chk(trap_cause == ec && trap_req == (ec != 0), tag, {60'd0, trap_req, trap_cause},
        {60'd0, ec != 0, ec});
    chk(sticky_flags == exp_sticky, wr ? "R12 clear-with-op" : (k != 0 ? "R5 sticky" : "R12"),
        64'(sticky_flags), 64'(exp_sticky));
    chk(nan_ovr == eo && nan_val == ev, (a >= 4 || b >= 4) ? "R9" : "R10",
        nan_val, ev);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks + 1);
    $finish;
  end

  initial begin : main
    int idx;
    repeat (3) @(negedge clk);
    chk(!trap_req && trap_cause == 0 && sticky_flags == 0 && !nan_ovr && nan_val == 0,
        "R1 in reset", {trap_req, trap_cause, sticky_flags}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!trap_req && trap_cause == 0 && sticky_flags == 0 && !nan_ovr,
        "R1 after release", {trap_req, trap_cause, sticky_flags}, 0);

    // Class pairs x kinds x qualifier x denormal-as-zero
    idx = 0;
    for (int k = 0; k < 4; k++)
      for (int a = 0; a < 6; a++)
        for (int b = 0; b < 6; b++)
          for (int s = 0; s < 2; s++)
            for (int d = 0; d < 2; d++) begin
              run_op(k, a, b, s[0], d[0], 5'((idx * 7) & 31), 5'((idx * 13) & 31), 1'b0);
              idx++;
            end

    // Idle cycle after an operation: no trap (R2)
    run_op(0, 2, 2, 1'b0, 1'b0, 5'b00001, 5'b00000, 1'b0);
    @(negedge clk);
    chk(!trap_req && trap_cause == 0, "R2 idle", {trap_req, trap_cause}, 0);

    // Raw condition x disable mask sweep on normal operands (R6 R7 R12)
    for (int r = 0; r < 32; r++)
      for (int m = 0; m < 32; m++)
        run_op(0, 2, 2, 1'b0, 1'b0, 5'(r), 5'(m), 1'b0);

    // Denormal trap is not masked by disables (R3), nor by qualifier alone (R4)
    run_op(0, 1, 2, 1'b1, 1'b0, 5'b11111, 5'b11111, 1'b0);
    run_op(0, 2, 1, 1'b0, 1'b1, 5'b00000, 5'b11111, 1'b0);

    // Disabled conditions still recorded, then write clears (R12)
    run_op(0, 2, 2, 1'b0, 1'b0, 5'b10110, 5'b11111, 1'b0);
    @(negedge clk);
    ctl_wr = 1'b1;
    @(negedge clk);
    ctl_wr = 1'b0;
    exp_sticky = '0;
    chk(sticky_flags == 0, "R12 write clears", 64'(sticky_flags), 0);
    run_op(0, 2, 2, 1'b0, 1'b0, 5'b11111, 5'b00000, 1'b0);
    run_op(0, 2, 2, 1'b0, 1'b0, 5'b00100, 5'b11111, 1'b1);
    run_op(1, 1, 5, 1'b0, 1'b0, 5'b11111, 5'b00000, 1'b0);

    @(negedge clk);
    chk(!trap_req && trap_cause == 0, "R2 final idle", {trap_req, trap_cause}, 0);
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule